// File: doc/BRIEF.md
# Slow-Clock Real-Time Counter with Snapshot and Event Timestamps

A free-running counter advances on every edge of a slow clock and is observed from a faster bus clock through a small register file. Software cannot read the live count directly. Instead it sets an update bit in the control register. A request/acknowledge handshake then carries a copy of the count into the bus domain. The bit drops once the copy has landed in the snapshot registers, and the value is read as a low word and a high word.

Two event inputs, one for entry into sleep and one for wake-up, each store the count into a timestamp pair of their own. The inputs may be asynchronous. A second control bit supports waiting for one slow cycle: software sets it, and it stays set until the slow domain has seen a clock edge and reported it back.

Top module: `rtc_snap_counter`

## Requirements
- R1: The counter starts at zero after reset, adds one on every slow clock edge while reset is released, and wraps to zero after 2^CNT_W - 1.
- R2: After reset every register (word addresses 0 to 6) reads as zero.
- R3: Writing 1 to bit 0 of word address 0 starts a snapshot. Bit 0 of that word reads 1 from the next bus cycle until the snapshot registers are loaded, and reads 0 after that.
- R4: The loaded snapshot lies between the count at the time of the write and the count when bit 0 clears, taken modulo 2^CNT_W. The snapshot registers do not change except when a snapshot completes.
- R5: The snapshot reads as the low WORD_W bits at word address 1 and the bits from WORD_W upward at word address 2. Bits of address 2 above the counter width read as zero.
- R6: A rising edge on sleep_evt stores, on the third slow edge after it, the count reached at the second slow edge. The stored value reads at word addresses 3 (low) and 4 (high).
- R7: A rising edge on wake_evt is stored the same way into word addresses 5 (low) and 6 (high), and it leaves the sleep pair unchanged.
- R8: Writing 1 to bit 1 of word address 0 makes that bit read 1 at least until the next slow edge, and it clears by itself within a few slow cycles. Bit 0 is not affected.
- R9: The event inputs act on edges only. Holding an event input high does not store the count again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bus clock |
| sclk | input | 1 | Slow counting clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en | input | 1 | Register write strobe (bus clock) |
| addr | input | 3 | Word address for reads and writes |
| wr_bits | input | 2 | Control write data: bit 0 snapshot update, bit 1 next-edge request |
| rd_data | output | WORD_W | Combinational read data of the addressed word |
| sleep_evt | input | 1 | Sleep-entry event, asynchronous level |
| wake_evt | input | 1 | Wake-up event, asynchronous level |

## Verification
An event timestamp is due on the third slow edge after the input rises. The bench raises each event just after a slow edge, keeps its own count of slow edges since reset, and expects exactly that count plus two. A snapshot has no fixed latency because of the handshake. The bench therefore records its edge count at the write and again when the update bit is seen clear, and accepts any value in that window. The next-edge bit is read a few bus cycles after a slow edge, before the following one, and again six slow cycles later. All reads take place one time unit after the address is set, clear of both clock edges.

// File: rtl/rtc_snap_pkg.sv
package rtc_snap_pkg;
  typedef enum logic [2:0] {
    REG_CTRL    = 3'd0,
    REG_SNAP_LO = 3'd1,
    REG_SNAP_HI = 3'd2,
    REG_SLP_LO  = 3'd3,
    REG_SLP_HI  = 3'd4,
    REG_WAKE_LO = 3'd5,
    REG_WAKE_HI = 3'd6,
    REG_NONE    = 3'd7
  } reg_sel_e;

  localparam int CTRL_UPD_BIT = 0;
  localparam int CTRL_NE_BIT  = 1;
  localparam int EVT_SLEEP    = 0;
  localparam int EVT_WAKE     = 1;
  localparam int NUM_EVT      = 2;

  // field of width w starting at bit lsb, zero-extended to 64 bits
  function automatic logic [63:0] word_slice(input logic [63:0] v,
                                             input int unsigned lsb,
                                             input int unsigned w);
    logic [63:0] mask;
    mask = (w >= 64) ? '1 : ((64'd1 << w) - 64'd1);
    return (v >> lsb) & mask;
  endfunction
endpackage

// File: rtl/rtc_sync2.sv
module rtc_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/rtc_slow_core.sv
module rtc_slow_core
  import rtc_snap_pkg::*;
#(
  parameter int CNT_W = 48
) (
  input  logic                            sclk,
  input  logic                            rst_n,
  input  logic [NUM_EVT-1:0]              evt_in,
  input  logic                            snap_req_t,
  input  logic                            ne_req_t,
  output logic [CNT_W-1:0]                count,
  output logic [CNT_W-1:0]                hold,
  output logic                            snap_ack_t,
  output logic                            ne_ack_t,
  output logic [NUM_EVT-1:0]              evt_hit,
  output logic [NUM_EVT-1:0][CNT_W-1:0]   evt_ts
);
  logic [NUM_EVT-1:0] evt_s, evt_d;
  logic [1:0]         req_s;
  logic               snap_take;

  // free-running count, wraps naturally
  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count + 1'b1;
  end

  rtc_sync2 #(.W(NUM_EVT)) u_evt_sync (
    .clk(sclk), .rst_n(rst_n), .d(evt_in), .q(evt_s));

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) evt_d <= '0;
    else        evt_d <= evt_s;
  end

  assign evt_hit = evt_s & ~evt_d;

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
    always_ff @(posedge sclk or negedge rst_n) begin
      if (!rst_n)          evt_ts[g] <= '0;
      else if (evt_hit[g]) evt_ts[g] <= count;
    end
  end

  // request toggles from the bus domain: bit1 next-edge, bit0 snapshot
  rtc_sync2 #(.W(2)) u_req_sync (
    .clk(sclk), .rst_n(rst_n), .d({ne_req_t, snap_req_t}), .q(req_s));

  assign snap_take = req_s[0] ^ snap_ack_t;

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      hold       <= '0;
      snap_ack_t <= 1'b0;
      ne_ack_t   <= 1'b0;
    end else begin
      if (snap_take) hold <= count;
      snap_ack_t <= req_s[0];
      ne_ack_t   <= req_s[1];
    end
  end
endmodule

// File: rtl/rtc_bus_regs.sv
module rtc_bus_regs
  import rtc_snap_pkg::*;
#(
  parameter int CNT_W  = 48,
  parameter int WORD_W = 32
) (
  input  logic                            bclk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [2:0]                      addr,
  input  logic [1:0]                      wr_bits,
  input  logic [CNT_W-1:0]                hold,
  input  logic                            snap_ack_t,
  input  logic                            ne_ack_t,
  input  logic [NUM_EVT-1:0][CNT_W-1:0]   evt_ts,
  output logic [WORD_W-1:0]               rd_data,
  output logic                            snap_req_t,
  output logic                            ne_req_t,
  output logic                            snap_busy,
  output logic                            snap_load,
  output logic                            ne_flag,
  output logic [CNT_W-1:0]                snap
);
  localparam int HI_W = CNT_W - WORD_W;

  logic [1:0] ack_s;
  logic       ctrl_wr;

  rtc_sync2 #(.W(2)) u_ack_sync (
    .clk(bclk), .rst_n(rst_n), .d({ne_ack_t, snap_ack_t}), .q(ack_s));

  assign ctrl_wr   = wr_en && (reg_sel_e'(addr) == REG_CTRL);
  assign snap_load = snap_busy && (ack_s[0] == snap_req_t);
  assign ne_flag   = ne_req_t ^ ack_s[1];

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      snap_busy  <= 1'b0;
      snap_req_t <= 1'b0;
      ne_req_t   <= 1'b0;
      snap       <= '0;
    end else begin
      if (ctrl_wr && wr_bits[CTRL_UPD_BIT] && !snap_busy) begin
        snap_busy  <= 1'b1;
        snap_req_t <= ~snap_req_t;
      end else if (snap_load) begin
        snap_busy <= 1'b0;
        snap      <= hold;
      end
      if (ctrl_wr && wr_bits[CTRL_NE_BIT] && !ne_flag)
        ne_req_t <= ~ne_req_t;
    end
  end

  function automatic logic [WORD_W-1:0] lo_of(input logic [CNT_W-1:0] v);
    return WORD_W'(word_slice(64'(v), 0, WORD_W));
  endfunction

  function automatic logic [WORD_W-1:0] hi_of(input logic [CNT_W-1:0] v);
    return WORD_W'(word_slice(64'(v), WORD_W, HI_W));
  endfunction

  always_comb begin
    case (reg_sel_e'(addr))
      REG_CTRL:    rd_data = WORD_W'({ne_flag, snap_busy});
      REG_SNAP_LO: rd_data = lo_of(snap);
      REG_SNAP_HI: rd_data = hi_of(snap);
      REG_SLP_LO:  rd_data = lo_of(evt_ts[EVT_SLEEP]);
      REG_SLP_HI:  rd_data = hi_of(evt_ts[EVT_SLEEP]);
      REG_WAKE_LO: rd_data = lo_of(evt_ts[EVT_WAKE]);
      REG_WAKE_HI: rd_data = hi_of(evt_ts[EVT_WAKE]);
      default:     rd_data = '0;
    endcase
  end
endmodule

// File: rtl/rtc_snap_counter.sv
module rtc_snap_counter
  import rtc_snap_pkg::*;
#(
  parameter int CNT_W  = 48,
  parameter int WORD_W = 32
) (
  input  logic              bclk,
  input  logic              sclk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        addr,
  input  logic [1:0]        wr_bits,
  output logic [WORD_W-1:0] rd_data,
  input  logic              sleep_evt,
  input  logic              wake_evt
);
  logic [CNT_W-1:0]              count, hold, snap;
  logic                          snap_req_t, snap_ack_t, ne_req_t, ne_ack_t;
  logic                          snap_busy, snap_load, ne_flag;
  logic [NUM_EVT-1:0]            evt_hit, evt_in;
  logic [NUM_EVT-1:0][CNT_W-1:0] evt_ts;

  assign evt_in[EVT_SLEEP] = sleep_evt;
  assign evt_in[EVT_WAKE]  = wake_evt;

  rtc_slow_core #(.CNT_W(CNT_W)) u_slow (
    .sclk(sclk), .rst_n(rst_n), .evt_in(evt_in),
    .snap_req_t(snap_req_t), .ne_req_t(ne_req_t),
    .count(count), .hold(hold), .snap_ack_t(snap_ack_t), .ne_ack_t(ne_ack_t),
    .evt_hit(evt_hit), .evt_ts(evt_ts));

  rtc_bus_regs #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_bus (
    .bclk(bclk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_bits(wr_bits),
    .hold(hold), .snap_ack_t(snap_ack_t), .ne_ack_t(ne_ack_t), .evt_ts(evt_ts),
    .rd_data(rd_data), .snap_req_t(snap_req_t), .ne_req_t(ne_req_t),
    .snap_busy(snap_busy), .snap_load(snap_load), .ne_flag(ne_flag), .snap(snap));
endmodule

// File: rtl/rtc_snap_chk.sv
module rtc_snap_chk
  import rtc_snap_pkg::*;
#(
  parameter int CNT_W = 48
) (
  input logic                            bclk,
  input logic                            sclk,
  input logic                            rst_n,
  input logic                            wr_en,
  input logic [2:0]                      addr,
  input logic [1:0]                      wr_bits,
  input logic [CNT_W-1:0]                count,
  input logic [CNT_W-1:0]                snap,
  input logic                            snap_busy,
  input logic                            snap_load,
  input logic                            ne_flag,
  input logic [NUM_EVT-1:0]              evt_hit,
  input logic [NUM_EVT-1:0][CNT_W-1:0]   evt_ts
);
  logic ctrl_wr;
  assign ctrl_wr = wr_en && (addr == 3'd0);

  assert_count_step_R1: assert property (@(posedge sclk) disable iff (!rst_n)
    1'b1 |=> count == CNT_W'($past(count) + 1'b1));

  assert_busy_set_R3: assert property (@(posedge bclk) disable iff (!rst_n)
    (ctrl_wr && wr_bits[0] && !snap_busy) |=> snap_busy);

  assert_snap_stable_R4: assert property (@(posedge bclk) disable iff (!rst_n)
    !snap_load |=> $stable(snap));

  assert_sleep_cap_R6: assert property (@(posedge sclk) disable iff (!rst_n)
    evt_hit[EVT_SLEEP] |=> evt_ts[EVT_SLEEP] == $past(count));

  assert_wake_cap_R7: assert property (@(posedge sclk) disable iff (!rst_n)
    evt_hit[EVT_WAKE] |=> evt_ts[EVT_WAKE] == $past(count));

  assert_ne_set_R8: assert property (@(posedge bclk) disable iff (!rst_n)
    (ctrl_wr && wr_bits[1] && !ne_flag) |=> ne_flag);
endmodule

bind rtc_snap_counter rtc_snap_chk #(.CNT_W(CNT_W)) u_chk (
  .bclk(bclk), .sclk(sclk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
  .wr_bits(wr_bits), .count(count), .snap(snap), .snap_busy(snap_busy),
  .snap_load(snap_load), .ne_flag(ne_flag), .evt_hit(evt_hit), .evt_ts(evt_ts));

// File: tb/rtc_snap_counter_tb.sv
module rtc_snap_counter_tb;
  localparam int BCLK_PERIOD = 10;
  localparam int SCLK_HALF   = 37;
  localparam int NW_CNT      = 12;
  localparam int NW_WORD     = 8;

  logic bclk = 1'b0, sclk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, n_wr_en = 1'b0;
  logic [2:0] addr = '0, n_addr = '0;
  logic [1:0] wr_bits = '0, n_wr_bits = '0;
  logic sleep_evt = 1'b0, wake_evt = 1'b0;
  logic [31:0] rd_data;
  logic [7:0]  n_rd_data;
  logic [63:0] m = '0;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(BCLK_PERIOD/2) bclk = ~bclk;
  always #(SCLK_HALF) sclk = ~sclk;

  // slow edges since reset release (the count per R1)
  always @(posedge sclk or negedge rst_n)
    if (!rst_n) m <= '0; else m <= m + 64'd1;

  rtc_snap_counter u_dut (
    .bclk(bclk), .sclk(sclk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wr_bits(wr_bits), .rd_data(rd_data), .sleep_evt(sleep_evt), .wake_evt(wake_evt));

  rtc_snap_counter #(.CNT_W(NW_CNT), .WORD_W(NW_WORD)) u_dut_narrow (
    .bclk(bclk), .sclk(sclk), .rst_n(rst_n), .wr_en(n_wr_en), .addr(n_addr),
    .wr_bits(n_wr_bits), .rd_data(n_rd_data), .sleep_evt(1'b0), .wake_evt(1'b0));

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input bit narrow, input logic [2:0] a, input logic [1:0] d);
    @(negedge bclk);
    if (narrow) begin n_wr_en = 1; n_addr = a; n_wr_bits = d; end
    else        begin wr_en = 1; addr = a; wr_bits = d; end
    @(posedge bclk); #1;
    wr_en = 0; n_wr_en = 0; wr_bits = 0; n_wr_bits = 0;
  endtask

  task automatic rd(input bit narrow, input logic [2:0] a, output logic [31:0] v);
    if (narrow) begin n_addr = a; #1 v = 32'(n_rd_data); end
    else        begin addr = a; #1 v = rd_data; end
  endtask

  // snapshot with completion window; returns value and window bounds
  task automatic take_snap(input bit narrow, output logic [63:0] val,
                           output logic [63:0] lo_m, output logic [63:0] hi_m);
    logic [31:0] c, l, h;
    int n;
    @(negedge bclk);
    lo_m = m;
    wr(narrow, 3'd0, 2'b01);
    rd(narrow, 3'd0, c);
    check(c[0] == 1'b1, "R3 update bit set after write", 64'(c), 64'd1);
    n = 0;
    while (c[0] && n < 200) begin
      @(negedge bclk); rd(narrow, 3'd0, c); n++;
    end
    hi_m = m;
    check(c[0] == 1'b0, "R3 update bit clears", 64'(c), 64'd0);
    rd(narrow, 3'd1, l);
    rd(narrow, 3'd2, h);
    if (narrow) begin
      check(h[7:4] == 4'd0, "R5 narrow high word upper bits", 64'(h), 64'(h[3:0]));
      val = {52'd0, h[3:0], l[7:0]};
    end else begin
      check(h[31:16] == 16'd0, "R5 high word upper bits", 64'(h), 64'(h[15:0]));
      val = {16'd0, h[15:0], l};
    end
  endtask

  task automatic test_reset();
    logic [31:0] v;
    for (int a = 0; a < 7; a++) begin
      rd(1'b0, 3'(a), v);
      check(v == 32'd0, "R2 reset value", 64'(v), 64'd0);
    end
    rd(1'b1, 3'd0, v);
    check(v == 32'd0, "R2 narrow reset ctrl", 64'(v), 64'd0);
  endtask

  task automatic test_snapshot();
    logic [63:0] v1, a1, b1, v2, a2, b2;
    logic [31:0] l, h;
    repeat (5) @(posedge sclk);
    take_snap(1'b0, v1, a1, b1);
    check(v1 >= a1 && v1 <= b1, "R4 snapshot window 1", v1, a1);
    repeat (23) @(posedge sclk);
    take_snap(1'b0, v2, a2, b2);
    check(v2 >= a2 && v2 <= b2, "R4 snapshot window 2", v2, a2);
    check(v2 > v1, "R1 count advances between snapshots", v2, v1);
    repeat (6) @(posedge sclk);
    @(negedge bclk);
    rd(1'b0, 3'd1, l); rd(1'b0, 3'd2, h);
    check({16'd0, h[15:0], l} == v2, "R4 snapshot holds without update",
          {16'd0, h[15:0], l}, v2);
  endtask

  task automatic evt_cap(input bit wake, output logic [63:0] exp);
    @(negedge sclk);
    exp = m + 64'd2;
    if (wake) wake_evt = 1; else sleep_evt = 1;
    repeat (3) @(posedge sclk);
    @(negedge sclk);
  endtask

  task automatic test_sleep();
    logic [63:0] e;
    logic [31:0] l, h;
    evt_cap(1'b0, e);
    rd(1'b0, 3'd3, l); rd(1'b0, 3'd4, h);
    check({h, l} == e, "R6 sleep timestamp", {h, l}, e);
    repeat (5) @(posedge sclk);
    @(negedge sclk);
    rd(1'b0, 3'd3, l); rd(1'b0, 3'd4, h);
    check({h, l} == e, "R9 held sleep input no recapture", {h, l}, e);
    sleep_evt = 0;
    repeat (3) @(posedge sclk);
  endtask

  task automatic test_wake();
    logic [63:0] e, s;
    logic [31:0] l, h;
    rd(1'b0, 3'd3, l); rd(1'b0, 3'd4, h);
    s = {h, l};
    repeat (4) @(posedge sclk);
    evt_cap(1'b1, e);
    rd(1'b0, 3'd5, l); rd(1'b0, 3'd6, h);
    check({h, l} == e, "R7 wake timestamp", {h, l}, e);
    rd(1'b0, 3'd3, l); rd(1'b0, 3'd4, h);
    check({h, l} == s, "R7 sleep pair untouched by wake", {h, l}, s);
    wake_evt = 0;
    repeat (2) @(posedge sclk);
  endtask

  task automatic test_next_edge();
    logic [31:0] c;
    @(posedge sclk); #2;
    wr(1'b0, 3'd0, 2'b10);
    rd(1'b0, 3'd0, c);
    check(c[1] == 1'b1, "R8 next-edge bit set before slow edge", 64'(c), 64'd2);
    check(c[0] == 1'b0, "R8 update bit unaffected", 64'(c), 64'd2);
    repeat (6) @(posedge sclk);
    @(negedge bclk);
    rd(1'b0, 3'd0, c);
    check(c[1] == 1'b0, "R8 next-edge bit self-clears", 64'(c), 64'd0);
  endtask

  task automatic test_wrap();
    logic [63:0] v, a, b, mask, diff;
    mask = (64'd1 << NW_CNT) - 64'd1;
    while (m < (64'd1 << NW_CNT) + 64'd50) @(posedge sclk);
    take_snap(1'b1, v, a, b);
    diff = (v - a) & mask;
    check(diff <= (b - a), "R1 narrow counter wraps modulo width", v, a & mask);
    check(v < a, "R1 wrapped value below edge count", v, a & mask);
  endtask

  initial begin
    #(BCLK_PERIOD * 180000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge sclk);
    test_reset();
    #1 rst_n = 1'b1;
    test_snapshot();
    test_sleep();
    test_wake();
    test_next_edge();
    test_wrap();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule